// File: doc/BRIEF.md
# Radix-4 Booth Multiplier with Signed/Unsigned Mode

This block multiplies two N-bit operands and returns their full 2N-bit product. A single mode input selects whether both operands are read as unsigned integers or as two's complement integers. The multiplier operand is recoded in radix 4. Overlapping three-bit windows step two bits at a time, with an implicit zero below the least significant bit. Each window selects 0, +1, +2, -1 or -2 times the multiplicand, so the number of partial-product rows is roughly half of N.

Each row is built by one combined select-and-invert cell per bit. Negation is done by inverting the selected multiple and then adding a single negate bit as a carry-in at the row's own weight. The rows are summed by a chain of ripple-carry adders, one adder per row. Each adder covers only the columns at and above the weight of its row. The combinational sum is captured in an output register.

The operands are widened before recoding. In unsigned mode they are zero-extended, which adds one extra row whenever the top multiplier bit is set. In signed mode they are sign-extended. With this widening, the top window recodes correctly in both modes.

Top module: `booth_mul`

## Requirements
- R1: While `rst` is high at a rising clock edge, `product` becomes zero at that edge, whatever the other inputs are.
- R2: With `signed_mode` = 0, `product` equals the unsigned product of `a` and `b` (2N bits, exact). It appears at the rising edge that samples the operands.
- R3: With `signed_mode` = 1, `product` equals the two's complement product of `a` and `b` as a 2N-bit two's complement value. It appears at the rising edge that samples the operands.
- R4: Each recoding window (bit order: upper, middle, lower) selects exactly one of zero, single or double magnitude. The negate control is set only for windows 100, 101 and 110.
- R5: Windows 000 and 111 contribute nothing. A multiplier of zero gives a zero product in both modes. A multiplier of all ones gives the product 0 - a in signed mode.
- R6: In unsigned mode, a multiplier with its top bit set is handled through the extra row. The all-ones by all-ones case gives (2^N - 1)^2.
- R7: Signed extremes are exact: most-negative times most-negative gives 2^(2N-2), and most-negative times -1 gives +2^(N-1).
- R8: The mode is sampled together with the operands on the same edge. Changing only `signed_mode` between consecutive cycles changes the product to match the mode of each cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| signed_mode | input | 1 | 0 = unsigned operands, 1 = two's complement operands |
| a | input | N | Multiplicand |
| b | input | N | Multiplier (recoded in radix 4) |
| product | output | 2N | Registered 2N-bit product |

## Verification
The product for a set of operands and mode is due one rising edge after those inputs are presented. The datapath is combinational up to that single output register. The bench drives each new stimulus at a falling edge and stores the behaviourally computed expectation. At the next falling edge, after exactly one rising edge has passed, it compares `product` with that stored value. A reset has the same one-edge delay: zero is expected at the first falling edge after a rising edge with `rst` high.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Controls for one radix-4 row: exactly one magnitude choice plus sign.
  typedef struct packed {
    logic zero;
    logic one;
    logic two;
    logic neg;
  } booth_sel_t;

  // Extended multiplier width: one guard bit, rounded up to an even count.
  function automatic int ext_width(input int n);
    return (n % 2 == 0) ? n + 2 : n + 1;
  endfunction

endpackage

// File: rtl/booth_triplet_recoder.sv
module booth_triplet_recoder
  import booth_mul_pkg::*;
(
  input  logic [2:0]  trip,
  output booth_sel_t  sel
);

  logic hi, mid, lo;
  assign hi  = trip[2];
  assign mid = trip[1];
  assign lo  = trip[0];

  assign sel.one  = mid ^ lo;
  assign sel.two  = (hi & ~mid & ~lo) | (~hi & mid & lo);
  assign sel.zero = (hi & mid & lo) | (~hi & ~mid & ~lo);
  assign sel.neg  = hi & ~(mid & lo);

  // R4: one magnitude choice per window; negate only on windows 100/101/110
  always_comb begin
    a_r4_one_magnitude: assert ($onehot({sel.zero, sel.one, sel.two}));
    a_r4_negate_codes: assert (sel.neg == (trip == 3'b100 || trip == 3'b101 || trip == 3'b110));
  end

endmodule

// File: rtl/booth_pp_row.sv
module booth_pp_row
  import booth_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N:0]   mcand_x,
  input  booth_sel_t   sel,
  output logic [N+1:0] row
);

  // One combined select/invert cell per bit position.
  for (genvar j = 0; j <= N + 1; j++) begin : g_cell
    logic cur_bit, low_bit, pick;
    if (j == 0) begin : g_lsb
      assign low_bit = 1'b0;
    end else begin : g_mid
      assign low_bit = mcand_x[j-1];
    end
    if (j <= N) begin : g_in
      assign cur_bit = mcand_x[j];
    end else begin : g_ext
      assign cur_bit = mcand_x[N];
    end
    assign pick   = (sel.one & cur_bit) | (sel.two & low_bit);
    assign row[j] = ~sel.zero & (pick ^ sel.neg);
  end

  // R5: a zero window yields an all-zero row
  always_comb begin
    a_r5_zero_row: assert (!sel.zero || row == '0);
  end

endmodule

// File: rtl/booth_ripple_add.sv
module booth_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum
);

  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar k = 0; k < W; k++) begin : g_fa
    assign sum[k]     = x[k] ^ y[k] ^ carry[k];
    assign carry[k+1] = (x[k] & y[k]) | (carry[k] & (x[k] ^ y[k]));
  end

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           signed_mode,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] product
);

  localparam int PW   = 2 * N;
  localparam int EB   = ext_width(N);
  localparam int ROWS = EB / 2;
  localparam int RW   = N + 2;

  logic [N:0]      mcand_x;
  logic [EB:0]     mplier_x;
  logic [PW-1:0]   acc [ROWS+1];

  assign mcand_x  = {signed_mode & a[N-1], a};
  assign mplier_x = {{(EB-N){signed_mode & b[N-1]}}, b, 1'b0};
  assign acc[0]   = '0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int SW = PW - 2 * r;
    booth_sel_t      sel;
    logic [RW-1:0]   row;
    logic [SW-1:0]   addend;
    logic [SW-1:0]   upper;

    booth_triplet_recoder u_rec (
      .trip (mplier_x[2*r+2 -: 3]),
      .sel  (sel)
    );

    booth_pp_row #(.N(N)) u_pp (
      .mcand_x (mcand_x),
      .sel     (sel),
      .row     (row)
    );

    if (SW > RW) begin : g_sext
      assign addend = {{(SW-RW){row[RW-1]}}, row};
    end else if (SW == RW) begin : g_fit
      assign addend = row;
    end else begin : g_trunc
      assign addend = row[SW-1:0];
    end

    booth_ripple_add #(.W(SW)) u_add (
      .x   (acc[r][PW-1:2*r]),
      .y   (addend),
      .cin (sel.neg),
      .sum (upper)
    );

    if (r == 0) begin : g_first
      assign acc[r+1] = upper;
    end else begin : g_next
      assign acc[r+1] = {upper, acc[r][2*r-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else     product <= acc[ROWS];
  end

  // R2: unsigned product one edge after sampling
  a_r2_unsigned_product: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(signed_mode)) |->
      product == PW'({{N{1'b0}}, $past(a)} * {{N{1'b0}}, $past(b)}));

  // R3: two's complement product one edge after sampling
  a_r3_signed_product: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(signed_mode)) |->
      product == PW'({{N{$past(a[N-1])}}, $past(a)} * {{N{$past(b[N-1])}}, $past(b)}));

  // R1: reset clears the output register
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;
  always @(negedge clk) begin
    if (rst_seen) a_r1_reset_clear: assert (product == '0);
  end

endmodule

// File: tb/sim_booth_mul.sv
`timescale 1ns/1ps
module sim_booth_mul;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [23:0] a24 = '0, b24 = '0;
  logic [15:0] p8;
  logic [47:0] p24;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  booth_mul #(.N(8)) u0 (
    .clk(clk), .rst(rst), .signed_mode(mode), .a(a8), .b(b8), .product(p8));

  booth_mul #(.N(24)) u1 (
    .clk(clk), .rst(rst), .signed_mode(mode), .a(a24), .b(b24), .product(p24));

  // Pending expectations (one-entry queue: result due one edge later)
  bit          pend = 1'b0;
  logic [15:0] exp8;
  logic [47:0] exp24;
  string       ptag;

  function automatic logic [15:0] ref8(input logic [7:0] x, input logic [7:0] y, input logic m);
    longint sx, sy;
    sx = m ? longint'($signed(x)) : longint'(x);
    sy = m ? longint'($signed(y)) : longint'(y);
    return 16'(sx * sy);
  endfunction

  function automatic logic [47:0] ref24(input logic [23:0] x, input logic [23:0] y, input logic m);
    longint sx, sy;
    sx = m ? longint'($signed(x)) : longint'(x);
    sy = m ? longint'($signed(y)) : longint'(y);
    return 48'(sx * sy);
  endfunction

  task automatic compare_pending();
    if (pend) begin
      checks++;
      if (p8 !== exp8) begin
        fails++;
        $display("FAIL %s N=8: got %0h expected %0h", ptag, p8, exp8);
      end
      checks++;
      if (p24 !== exp24) begin
        fails++;
        $display("FAIL %s N=24: got %0h expected %0h", ptag, p24, exp24);
      end
    end
  endtask

  task automatic step(input logic [7:0] x8, input logic [7:0] y8,
                      input logic [23:0] x24, input logic [23:0] y24,
                      input logic m, input string tag);
    @(negedge clk);
    compare_pending();
    a8 = x8; b8 = y8; a24 = x24; b24 = y24; mode = m;
    exp8  = ref8(x8, y8, m);
    exp24 = ref24(x24, y24, m);
    ptag  = tag;
    pend  = 1'b1;
  endtask

  task automatic check_zero(input string tag);
    @(negedge clk);
    checks++;
    if (p8 !== '0 || p24 !== '0) begin
      fails++;
      $display("FAIL %s: got %0h/%0h expected 0/0", tag, p8, p24);
    end
  endtask

  initial begin
    // R1: reset with nonzero operands
    a8 = 8'hA5; b8 = 8'h3C; a24 = 24'h123456; b24 = 24'h654321; mode = 1'b1;
    repeat (3) @(posedge clk);
    check_zero("R1");
    @(negedge clk);
    rst = 1'b0;

    // R5: zero multiplier and all-ones multiplier
    step(8'h9B, 8'h00, 24'hABCDEF, 24'h000000, 1'b0, "R5");
    step(8'h9B, 8'h00, 24'hABCDEF, 24'h000000, 1'b1, "R5");
    step(8'h37, 8'hFF, 24'h0ABCDE, 24'hFFFFFF, 1'b1, "R5");
    // R6: unsigned top-bit multiplier needs the extra row
    step(8'hFF, 8'hFF, 24'hFFFFFF, 24'hFFFFFF, 1'b0, "R6");
    step(8'h81, 8'h80, 24'h800001, 24'h800000, 1'b0, "R6");
    // R7: signed extremes
    step(8'h80, 8'h80, 24'h800000, 24'h800000, 1'b1, "R7");
    step(8'h80, 8'hFF, 24'h800000, 24'hFFFFFF, 1'b1, "R7");
    step(8'h7F, 8'h80, 24'h7FFFFF, 24'h800000, 1'b1, "R7");
    // R8: same operands, mode toggled cycle by cycle
    step(8'hC8, 8'hF3, 24'hC80000, 24'hF30001, 1'b0, "R8");
    step(8'hC8, 8'hF3, 24'hC80000, 24'hF30001, 1'b1, "R8");
    step(8'hC8, 8'hF3, 24'hC80000, 24'hF30001, 1'b0, "R8");

    // R1: reset in mid-stream clears the product
    @(negedge clk);
    compare_pending();
    pend = 1'b0;
    rst = 1'b1;
    check_zero("R1");
    @(negedge clk);
    rst = 1'b0;

    // R2/R3/R4: exhaustive N=8, random N=24, both modes
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          step(8'(x), 8'(y), 24'($urandom), 24'($urandom), 1'(m), (m == 1) ? "R3/R4" : "R2/R4");
        end
      end
    end
    @(negedge clk);
    compare_pending();
    pend = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule